// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Gain Stage

This block sits in a stereo sample path and applies a gain that moves between silence and full level along a raised-cosine curve, so that muting and unmuting never produce an audible step. Each sample strobe advances the curve by one position. A fixed number of strobes therefore carries the gain from zero to unity, or from unity back to zero. A mute request that changes partway through a fade turns the fade around from the position it has reached.

The mute request comes from one of two sources: a dedicated pin, used when the block is strapped for static control, or a mute bit held by a register control path. A select input picks the source. A 5-bit volume code scales both channels on top of the mute curve. Left and right samples always get the same combined gain. The block leaves reset fully muted and reports through a flag when the fade rests at either end.

Top module: `soft_mute_ramp`

## Requirements
- R1: During and right after reset, before any strobe, `out_l` and `out_r` are 0, `out_stb` is 0 and `ramp_done` is 1. The ramp position is 0, meaning fully muted.
- R2: When `ctl_mode` is 1 the mute request is `mute_bit` and `mute_pin` has no effect. When `ctl_mode` is 0 the request is `mute_pin` and `mute_bit` has no effect. A request of 1 means mute.
- R3: The ramp position, an integer from 0 to 32, changes only on a clock edge where `smp_stb` is 1. On such an edge it moves by one toward 0 when the request is 1, and by one toward 32 when the request is 0. It holds when it is already at that end.
- R4: The mute gain at position k is round(32768 × (1 − cos(π·k/32)) / 2), in Q15. This gives 0 at k = 0 and 32768, which is unity, at k = 32.
- R5: `ramp_done` is 1 exactly when the position is 0 or 32. A full fade from either end to the other takes 32 strobes.
- R6: When the request changes in the middle of a fade, the next strobe moves the position one step back the way it came. The position never jumps.
- R7: The volume gain is (32 − `vol_code`) × 1024 in Q15. Code 0 is unity and code 31 is 1/32.
- R8: The combined gain is g = floor((mute_gain × vol_gain + 16384) / 32768). Each output equals floor((sample × g + 16384) / 32768), saturated to the signed 24-bit range. The left and right channels use the same g.
- R9: A strobe on edge n loads the outputs using the gain at the position held before edge n, and raises `out_stb` for the one cycle after edge n. Between strobes the outputs hold their values and `out_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe marking a new stereo sample |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| ctl_mode | input | 1 | Mute source select: 0 pin, 1 register bit |
| mute_pin | input | 1 | Mute request from the static pin |
| mute_bit | input | 1 | Mute request from the control register |
| vol_code | input | 5 | Volume attenuation code |
| out_l | output | 24 | Scaled left sample, signed |
| out_r | output | 24 | Scaled right sample, signed |
| out_stb | output | 1 | Output sample valid for one cycle |
| ramp_done | output | 1 | Fade rests fully muted or at unity |

## Verification
The checker assumes that every input holds a known 0 or 1 once reset is released. It makes no assumption about strobe spacing, so back-to-back strobes are also covered by its properties. The bench changes inputs only on falling edges, gives each strobe a single cycle with at least one idle cycle after it, and changes the mute source, request level and volume code only between strobes. Each strobe is therefore checked against one well-defined model position and one gain.

// File: rtl/sm_pkg.sv
package sm_pkg;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_REG = 1'b1
   } mute_src_e;

   // Raised-cosine level at position k of a fade that is `steps` long, in Q(frac)
   function automatic int unsigned rc_coef(int k, int steps, int frac);
      real ang;
      real lvl;
      ang = 3.14159265358979323846 * real'(k) / real'(steps);
      lvl = (1.0 - $cos(ang)) * 0.5 * real'(longint'(1) << frac);
      return $rtoi(lvl + 0.5);
   endfunction

endpackage

// File: rtl/sm_ramp_ctrl.sv
module sm_ramp_ctrl #(
   parameter int STEPS = 32,
   parameter int POS_W = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             req,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] TOP = POS_W'(STEPS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (stb) begin
         if (req && pos != '0) begin
            pos <= pos - 1'b1;
         end else if (!req && pos != TOP) begin
            pos <= pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sm_coef_rom.sv
module sm_coef_rom #(
   parameter int STEPS  = 32,
   parameter int FRAC   = 15,
   parameter int POS_W  = $clog2(STEPS + 1),
   parameter int GAIN_W = FRAC + 1
) (
   input  logic [POS_W-1:0]  pos,
   output logic [GAIN_W-1:0] coef
);

   logic [GAIN_W-1:0] tbl [STEPS+1];

   for (genvar k = 0; k <= STEPS; k++) begin : g_ent
      localparam int unsigned CV = sm_pkg::rc_coef(k, STEPS, FRAC);
      assign tbl[k] = GAIN_W'(CV);
   end

   always_comb begin
      coef = '0;
      for (int k = 0; k <= STEPS; k++) begin
         if (pos == POS_W'(k)) coef = tbl[k];
      end
   end

endmodule

// File: rtl/sm_scaler.sv
module sm_scaler #(
   parameter int DATA_W = 24,
   parameter int FRAC   = 15,
   parameter int GAIN_W = FRAC + 1,
   parameter bit SAT_EN = 1'b1
) (
   input  logic signed [DATA_W-1:0] din,
   input  logic        [GAIN_W-1:0] gain,
   output logic signed [DATA_W-1:0] dout
);

   localparam int PROD_W = DATA_W + GAIN_W + 1;
   localparam int SH_W   = PROD_W - FRAC;

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] biased;
   logic signed [SH_W-1:0]   shifted;

   always_comb begin
      prod    = PROD_W'(din) * PROD_W'($signed({1'b0, gain}));
      biased  = prod + (PROD_W'(1) << (FRAC - 1));
      shifted = SH_W'(biased >>> FRAC);
   end

   if (SAT_EN) begin : g_sat
      logic [SH_W-DATA_W:0] hi;
      assign hi = shifted[SH_W-1:DATA_W-1];
      always_comb begin
         if (hi == '0 || hi == '1) begin
            dout = shifted[DATA_W-1:0];
         end else if (shifted[SH_W-1]) begin
            dout = {1'b1, {(DATA_W-1){1'b0}}};
         end else begin
            dout = {1'b0, {(DATA_W-1){1'b1}}};
         end
      end
   end else begin : g_wrap
      assign dout = shifted[DATA_W-1:0];
   end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
   parameter int DATA_W = 24,
   parameter int STEPS  = 32,
   parameter int FRAC   = 15,
   parameter int VOL_W  = 5,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic signed [DATA_W-1:0] in_l,
   input  logic signed [DATA_W-1:0] in_r,
   input  logic                     ctl_mode,
   input  logic                     mute_pin,
   input  logic                     mute_bit,
   input  logic [VOL_W-1:0]         vol_code,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r,
   output logic                     out_stb,
   output logic                     ramp_done
);

   localparam int POS_W     = $clog2(STEPS + 1);
   localparam int GAIN_W    = FRAC + 1;
   localparam int VOL_STEPS = 2 ** VOL_W;

   if (STEPS < 2) begin : g_bad_steps
      $error("soft_mute_ramp: STEPS must be at least 2");
   end
   if (FRAC < VOL_W) begin : g_bad_frac
      $error("soft_mute_ramp: FRAC must not be below VOL_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("soft_mute_ramp: DATA_W must be at least 8");
   end

   logic                     mute_req;
   logic [POS_W-1:0]         ramp_pos;
   logic [GAIN_W-1:0]        mute_coef;
   logic [GAIN_W-1:0]        vol_gain;
   logic [2*GAIN_W-1:0]      gain_prod;
   logic [GAIN_W-1:0]        tot_gain;
   logic signed [DATA_W-1:0] scl_l;
   logic signed [DATA_W-1:0] scl_r;

   assign mute_req = (sm_pkg::mute_src_e'(ctl_mode) == sm_pkg::SRC_REG) ? mute_bit : mute_pin;

   sm_ramp_ctrl #(.STEPS(STEPS), .POS_W(POS_W)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (smp_stb),
      .req  (mute_req),
      .pos  (ramp_pos)
   );

   sm_coef_rom #(.STEPS(STEPS), .FRAC(FRAC), .POS_W(POS_W), .GAIN_W(GAIN_W)) u_rom (
      .pos (ramp_pos),
      .coef(mute_coef)
   );

   always_comb begin
      vol_gain  = GAIN_W'(VOL_STEPS - int'(vol_code)) << (FRAC - VOL_W);
      gain_prod = (2*GAIN_W)'(mute_coef) * (2*GAIN_W)'(vol_gain);
      tot_gain  = GAIN_W'((gain_prod + ((2*GAIN_W)'(1) << (FRAC - 1))) >> FRAC);
   end

   sm_scaler #(.DATA_W(DATA_W), .FRAC(FRAC), .GAIN_W(GAIN_W), .SAT_EN(SAT_EN)) u_scl_l (
      .din (in_l),
      .gain(tot_gain),
      .dout(scl_l)
   );

   sm_scaler #(.DATA_W(DATA_W), .FRAC(FRAC), .GAIN_W(GAIN_W), .SAT_EN(SAT_EN)) u_scl_r (
      .din (in_r),
      .gain(tot_gain),
      .dout(scl_r)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_l   <= '0;
         out_r   <= '0;
         out_stb <= 1'b0;
      end else begin
         out_stb <= smp_stb;
         if (smp_stb) begin
            out_l <= scl_l;
            out_r <= scl_r;
         end
      end
   end

   assign ramp_done = (ramp_pos == '0) || (ramp_pos == POS_W'(STEPS));

endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
   parameter int DATA_W = 24,
   parameter int STEPS  = 32,
   parameter int FRAC   = 15,
   parameter int POS_W  = $clog2(STEPS + 1),
   parameter int GAIN_W = FRAC + 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     smp_stb,
   input logic                     req,
   input logic [POS_W-1:0]         pos,
   input logic [GAIN_W-1:0]        coef,
   input logic signed [DATA_W-1:0] out_l,
   input logic signed [DATA_W-1:0] out_r,
   input logic                     out_stb,
   input logic                     ramp_done
);

   localparam logic [POS_W-1:0]  TOP = POS_W'(STEPS);
   localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1) << FRAC;

   p_hold_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(pos));

   p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= TOP);

   p_zero_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0) |-> (coef == '0));

   p_unity_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == TOP) |-> (coef == ONE));

   p_done_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_done |-> (coef == '0 || coef == ONE));

   p_down_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && req && pos != '0) |=> (pos == $past(pos) - 1'b1));

   p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && !req && pos != TOP) |=> (pos == $past(pos) + 1'b1));

   p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && coef == '0) |=> (out_l == '0 && out_r == '0));

   p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> out_stb);

   p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> (!out_stb && $stable(out_l) && $stable(out_r)));

endmodule

bind soft_mute_ramp sm_checker #(
   .DATA_W(DATA_W),
   .STEPS (STEPS),
   .FRAC  (FRAC),
   .POS_W (POS_W),
   .GAIN_W(GAIN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_stb  (smp_stb),
   .req      (mute_req),
   .pos      (ramp_pos),
   .coef     (mute_coef),
   .out_l    (out_l),
   .out_r    (out_r),
   .out_stb  (out_stb),
   .ramp_done(ramp_done)
);

// File: tb/tb_soft_mute_ramp.sv
`timescale 1ns/1ps
module tb_soft_mute_ramp;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_stb = 1'b0;
   logic signed [23:0] in_l = '0;
   logic signed [23:0] in_r = '0;
   logic               ctl_mode = 1'b1;
   logic               mute_pin = 1'b0;
   logic               mute_bit = 1'b1;
   logic [4:0]         vol_code = '0;
   logic signed [23:0] out_l;
   logic signed [23:0] out_r;
   logic               out_stb;
   logic               ramp_done;

   int  n_chk  = 0;
   int  n_fail = 0;
   int  mpos   = 0;
   int  seed_i = 0;
   bit  ended  = 1'b0;

   always #4 clk = ~clk;

   soft_mute_ramp dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .in_l(in_l), .in_r(in_r),
      .ctl_mode(ctl_mode), .mute_pin(mute_pin), .mute_bit(mute_bit),
      .vol_code(vol_code), .out_l(out_l), .out_r(out_r), .out_stb(out_stb),
      .ramp_done(ramp_done)
   );

   task automatic chk(string tag, bit ok, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic longint cos_gain(int k);
      real lvl;
      lvl = (1.0 - $cos(3.14159265358979323846 * real'(k) / 32.0)) * 16384.0;
      return longint'($rtoi(lvl + 0.5));
   endfunction

   function automatic longint model_out(longint s, int k, int code);
      longint g;
      longint q;
      g = (cos_gain(k) * longint'((32 - code) * 1024) + 16384) >>> 15;
      q = (s * g + 16384) >>> 15;
      if (q > 8388607) q = 8388607;
      if (q < -8388608) q = -8388608;
      return q;
   endfunction

   function automatic int pattern(int i);
      return ((i * 2654435 + 777) % 16777216) - 8388608;
   endfunction

   task automatic strobe(int l, int r, string tag);
      longint el;
      longint er;
      bit     rq;
      @(negedge clk);
      in_l = 24'(l);
      in_r = 24'(r);
      smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      el = model_out(longint'(l), mpos, int'(vol_code));
      er = model_out(longint'(r), mpos, int'(vol_code));
      chk({tag, " left"}, longint'(out_l) == el, longint'(out_l), el);
      chk({tag, " right"}, longint'(out_r) == er, longint'(out_r), er);
      chk("R9 out_stb", out_stb == 1'b1, longint'(out_stb), 1);
      rq = ctl_mode ? mute_bit : mute_pin;
      if (rq && mpos > 0) mpos--;
      else if (!rq && mpos < 32) mpos++;
      chk("R5 ramp_done", ramp_done == (mpos == 0 || mpos == 32),
          longint'(ramp_done), longint'(mpos == 0 || mpos == 32));
   endtask

   task automatic pat_strobes(int n, string tag);
      for (int i = 0; i < n; i++) begin
         strobe(pattern(seed_i), -pattern(seed_i + 3) / 3, tag);
         seed_i++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog: act=%0d exp=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: state held in and after reset
      repeat (3) @(negedge clk);
      chk("R1 out_l in reset", out_l == 0, longint'(out_l), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 out_l", out_l == 0, longint'(out_l), 0);
      chk("R1 out_r", out_r == 0, longint'(out_r), 0);
      chk("R1 out_stb", out_stb == 0, longint'(out_stb), 0);
      chk("R1 ramp_done", ramp_done == 1, longint'(ramp_done), 1);

      // R2: register source selected and muting; pin low must not unmute
      ctl_mode = 1'b1; mute_bit = 1'b1; mute_pin = 1'b0;
      pat_strobes(4, "R2 reg source mute");

      // R4: full fade-in through every raised-cosine position at unity volume
      mute_bit = 1'b0;
      pat_strobes(32, "R4 fade-in");
      chk("R5 at top after 32 strobes", mpos == 32, mpos, 32);
      pat_strobes(2, "R5 rest at unity");

      // R7: every volume code at full mute gain
      for (int c = 0; c < 32; c++) begin
         vol_code = 5'(c);
         strobe(8388607, -8388608, "R7 volume extremes");
         strobe(pattern(c * 7), pattern(c * 7 + 1), "R7 volume pattern");
      end

      // R9 and R3: no strobe means outputs and position hold
      begin
         logic signed [23:0] hl;
         logic signed [23:0] hr;
         hl = out_l;
         hr = out_r;
         for (int i = 0; i < 5; i++) begin
            in_l = 24'(pattern(i + 50));
            in_r = 24'(pattern(i + 60));
            @(negedge clk);
            chk("R9 idle out_stb", out_stb == 0, longint'(out_stb), 0);
            chk("R9 idle out_l", out_l == hl, longint'(out_l), longint'(hl));
            chk("R9 idle out_r", out_r == hr, longint'(out_r), longint'(hr));
         end
      end
      strobe(1000000, -1000000, "R3 position held while idle");

      // R2 and R6: pin source, register bit ignored, reversals mid-fade
      vol_code = 5'd7;
      ctl_mode = 1'b0; mute_pin = 1'b1; mute_bit = 1'b0;
      pat_strobes(12, "R6 fade-down by pin");
      chk("R2 pin source drove fade", mpos == 20, mpos, 20);
      mute_pin = 1'b0; mute_bit = 1'b1;
      pat_strobes(5, "R6 reversal up");
      chk("R6 position after reversal", mpos == 25, mpos, 25);
      mute_pin = 1'b1;
      pat_strobes(28, "R6 reversal down to silence");
      chk("R6 rests at zero", mpos == 0, mpos, 0);

      // R8: fade-in with unity volume, then full-scale samples
      vol_code = 5'd0; ctl_mode = 1'b1; mute_bit = 1'b0;
      for (int i = 0; i < 32; i++) begin
         strobe(8388607, -8388608, "R8 full-scale fade");
      end
      strobe(-8388608, 8388607, "R8 unity full-scale");
      strobe(1, -1, "R8 rounding small");
      strobe(0, 4095, "R8 rounding mid");

      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule